// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor

This block recovers a 128-bit plaintext block from a 128-bit ciphertext block under a 128-bit cipher key. It runs the straight inverse cipher on a single round datapath that is reused for all ten rounds. Each pass takes the zero-resettable state register through three steps: a fused step that undoes the byte substitution and the row rotation in one move, an XOR with the round key, and the inverse column mix. The inverse column mix is skipped in the final pass.

Round keys come from an expansion unit that derives all eleven keys from the key that was latched at start. They are consumed from the last key back to the first. On the start cycle the ciphertext is XORed with round key 10. Pass r (1..10) then applies round key 10−r.

The control logic has two states. ST_IDLE waits for `start` and moves to ST_ROUND when `start` is high. ST_ROUND runs one pass per clock, stays there while the pass counter is below 10, and returns to ST_IDLE on pass 10. On that last pass it also loads `pt_out` and raises `done` for one cycle.

Top module: `aes128_inv_iter`

## Requirements
- R1: After reset, `done` and `busy` are 0 and `pt_out` is all zero.
- R2: Ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a with key 000102030405060708090a0b0c0d0e0f decrypts to 00112233445566778899aabbccddeeff. All 128-bit values are written most significant byte first, and byte k of a block belongs to column k/4, row k%4.
- R3: Other blocks decrypt correctly, among them an all-zero key with ciphertext 66e94bd4ef8a2c3b884cfa59ca342b2e (plaintext zero) and key 2b7e151628aed2a6abf7158809cf4f3c with ciphertext 3925841d02dc09fbdc118597196a0b32 (plaintext 3243f6a8885a308d313198a2e0370734).
- R4: If `start` is sampled at clock edge N, `busy` is high from edge N to edge N+10, and `done` is high for exactly one cycle, starting at edge N+10.
- R5: A `start` that arrives while `busy` is high is ignored. It produces no extra `done` and does not alter the running result.
- R6: `pt_out` holds its value between completions.
- R7: A `start` presented in the cycle where `done` is high is accepted.
- R8: `key_in` and `ct_in` are sampled only at the start edge, so changing them during a run does not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decryption; sampled only in ST_IDLE |
| key_in | input | 128 | Cipher key, sampled at start |
| ct_in | input | 128 | Ciphertext block, sampled at start |
| busy | output | 1 | High while in ST_ROUND |
| done | output | 1 | One-cycle completion pulse |
| pt_out | output | 128 | Decrypted block, held until the next completion |

## Verification
The hardest case to reach from the ports is a start request that lands inside a run. In that case the inputs seen by the datapath differ from the latched ones while the key mux is still selecting the latched key. To reach it, the stimulus pulses `start` with a different key and ciphertext a few passes into a run and leaves that garbage on the inputs. The scoreboard then requires the original plaintext on time and treats any extra `done` as a failure. Back-to-back operation is reached by issuing the next block in the very cycle where `done` is observed.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

    typedef enum logic {ST_IDLE, ST_ROUND} phase_t;

    function automatic logic [7:0] gf_xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = gf_xt(p);
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse; zero maps to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] acc;
        logic [7:0] p;
        logic [7:0] e;
        acc = 8'h01;
        p   = a;
        e   = 8'd254;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) acc = gf_mul(acc, p);
            p = gf_mul(p, p);
        end
        return acc;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
        logic [15:0] d;
        d = {x, x} << n;
        return d[15:8];
    endfunction

    function automatic logic [7:0] fwd_sub(input logic [7:0] x);
        logic [7:0] y;
        y = gf_inv(x);
        return y ^ rotl8(y, 1) ^ rotl8(y, 2) ^ rotl8(y, 3) ^ rotl8(y, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] inv_sub(input logic [7:0] x);
        logic [7:0] y;
        y = rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05;
        return gf_inv(y);
    endfunction

    function automatic logic [7:0] round_const(input int idx);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 1; i < idx; i++) r = gf_xt(r);
        return r;
    endfunction

endpackage

// File: rtl/aes_key_sched.sv
module aes_key_sched
    import aes_inv_pkg::*;
#(
    parameter int NR = 10
) (
    input  logic [127:0] key_i,
    output logic [127:0] rk_o [0:NR]
);
    logic [127:0] chain [0:NR];

    assign chain[0] = key_i;

    generate
        for (genvar g = 1; g <= NR; g++) begin : g_step
            logic [31:0] w0, w1, w2, w3, rot, t, n0, n1, n2, n3;
            assign {w0, w1, w2, w3} = chain[g-1];
            assign rot = {w3[23:0], w3[31:24]};
            assign t = {fwd_sub(rot[31:24]) ^ round_const(g), fwd_sub(rot[23:16]),
                        fwd_sub(rot[15:8]), fwd_sub(rot[7:0])};
            assign n0 = w0 ^ t;
            assign n1 = w1 ^ n0;
            assign n2 = w2 ^ n1;
            assign n3 = w3 ^ n2;
            assign chain[g] = {n0, n1, n2, n3};
        end
        for (genvar g = 0; g <= NR; g++) begin : g_out
            assign rk_o[g] = chain[g];
        end
    endgenerate
endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
    import aes_inv_pkg::*;
(
    input  logic [127:0] state_i,
    input  logic [127:0] rk_i,
    input  logic         last_i,
    output logic [127:0] state_o
);
    logic [7:0] in_b [16];
    logic [7:0] kx_b [16];
    logic [7:0] mx_b [16];
    logic [7:0] a0, a1, a2, a3;

    always_comb begin
        for (int k = 0; k < 16; k++) in_b[k] = state_i[127-8*k -: 8];
        // fused inverse substitution + right rotation of row r by r bytes, then key XOR
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                kx_b[4*c+r] = inv_sub(in_b[4*((c-r+4)%4)+r]) ^ rk_i[127-8*(4*c+r) -: 8];
            end
        end
        for (int c = 0; c < 4; c++) begin
            a0 = kx_b[4*c];
            a1 = kx_b[4*c+1];
            a2 = kx_b[4*c+2];
            a3 = kx_b[4*c+3];
            mx_b[4*c]   = gf_mul(8'h0e, a0) ^ gf_mul(8'h0b, a1) ^ gf_mul(8'h0d, a2) ^ gf_mul(8'h09, a3);
            mx_b[4*c+1] = gf_mul(8'h09, a0) ^ gf_mul(8'h0e, a1) ^ gf_mul(8'h0b, a2) ^ gf_mul(8'h0d, a3);
            mx_b[4*c+2] = gf_mul(8'h0d, a0) ^ gf_mul(8'h09, a1) ^ gf_mul(8'h0e, a2) ^ gf_mul(8'h0b, a3);
            mx_b[4*c+3] = gf_mul(8'h0b, a0) ^ gf_mul(8'h0d, a1) ^ gf_mul(8'h09, a2) ^ gf_mul(8'h0e, a3);
        end
        for (int k = 0; k < 16; k++) state_o[127-8*k -: 8] = last_i ? kx_b[k] : mx_b[k];
    end
endmodule

// File: rtl/aes128_inv_iter.sv
module aes128_inv_iter
    import aes_inv_pkg::*;
#(
    parameter int ROUNDS = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [127:0] key_in,
    input  logic [127:0] ct_in,
    output logic         busy,
    output logic         done,
    output logic [127:0] pt_out
);
    localparam int CW = $clog2(ROUNDS + 1);

    phase_t          phase_q, phase_d;
    logic [CW-1:0]   rnd_q;
    logic [127:0]    key_q;
    logic [127:0]    state_q;
    logic [127:0]    key_src;
    logic [127:0]    rk_all [0:ROUNDS];
    logic [127:0]    rk_sel;
    logic [127:0]    round_out;
    logic [CW-1:0]   kidx;
    logic            last;

    assign key_src = (phase_q == ST_IDLE) ? key_in : key_q;
    assign kidx    = CW'(ROUNDS) - rnd_q;
    assign rk_sel  = rk_all[kidx];
    assign last    = (rnd_q == CW'(ROUNDS));
    assign busy    = (phase_q == ST_ROUND);

    aes_key_sched #(.NR(ROUNDS)) u_sched (
        .key_i (key_src),
        .rk_o  (rk_all)
    );

    aes_inv_round u_round (
        .state_i (state_q),
        .rk_i    (rk_sel),
        .last_i  (last),
        .state_o (round_out)
    );

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            ST_IDLE:  if (start) phase_d = ST_ROUND;
            ST_ROUND: if (last)  phase_d = ST_IDLE;
            default:             phase_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= ST_IDLE;
        else        phase_q <= phase_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q   <= '0;
            key_q   <= '0;
            state_q <= '0;
            pt_out  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase_q)
                ST_IDLE: begin
                    if (start) begin
                        key_q   <= key_in;
                        state_q <= ct_in ^ rk_all[ROUNDS];
                        rnd_q   <= CW'(1);
                    end
                end
                ST_ROUND: begin
                    state_q <= round_out;
                    if (last) begin
                        pt_out <= round_out;
                        done   <= 1'b1;
                        rnd_q  <= '0;
                    end else begin
                        rnd_q <= rnd_q + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R4
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));                                 // R4
    AST_RND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rnd_q >= CW'(1) && rnd_q <= CW'(ROUNDS)));          // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> (busy && !done));                // R5
    AST_PT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(pt_out));                                   // R6
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);                                   // R7
endmodule

// File: tb/tb_aes128_inv_iter.sv
module tb_aes128_inv_iter;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key_in = '0;
    logic [127:0] ct_in = '0;
    logic         busy, done;
    logic [127:0] pt_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int stray = 0;
    bit finished = 1'b0;
    bit prev_done = 1'b0;

    typedef struct {
        logic [127:0] exp;
        int           due;
        string        tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    aes128_inv_iter dut (
        .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in),
        .ct_in(ct_in), .busy(busy), .done(done), .pt_out(pt_out)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: caller is at a negedge
    task automatic issue(input logic [127:0] ct, input logic [127:0] key, input logic [127:0] exp, input string tag);
        item_t it;
        ct_in  = ct;
        key_in = key;
        start  = 1'b1;
        it.exp = exp;
        it.due = cyc + 11;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R4 busy after start", {127'd0, busy}, 128'd1);
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check(done == 1'b0, "R4 done width", {127'd0, done}, 128'd0);
            if (done) begin
                if (sb_q.size() == 0) begin
                    stray++;
                    check(1'b0, "R5 unexpected done", 128'd1, 128'd0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(pt_out == it.exp, it.tag, pt_out, it.exp);
                    check(cyc == it.due, "R4 latency", 128'(cyc), 128'(it.due));
                end
            end
            prev_done = done;
        end
    end

    initial begin
        while (cyc < 5000 && !finished) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<5000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] hold;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R1 flags after reset", {126'd0, done, busy}, 128'd0);
        check(pt_out == '0, "R1 pt after reset", pt_out, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h000102030405060708090a0b0c0d0e0f,
              128'h00112233445566778899aabbccddeeff, "R2 known vector");
        drain();
        issue(128'h3925841d02dc09fbdc118597196a0b32, 128'h2b7e151628aed2a6abf7158809cf4f3c,
              128'h3243f6a8885a308d313198a2e0370734, "R3 second vector");
        drain();
        issue(128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 128'h0,
              128'h0, "R3 zero key vector");
        drain();

        // R5 / R8: start and new inputs mid-run
        issue(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h000102030405060708090a0b0c0d0e0f,
              128'h00112233445566778899aabbccddeeff, "R5 R8 result with mid-run start");
        repeat (2) @(negedge clk);
        key_in = 128'hdeadbeefcafef00d0123456789abcdef;
        ct_in  = 128'h55aa55aa55aa55aa55aa55aa55aa55aa;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        check(busy == 1'b1, "R5 still busy", {127'd0, busy}, 128'd1);
        drain();
        repeat (15) @(negedge clk);
        check(stray == 0, "R5 no extra done", 128'(stray), 128'd0);

        // R6: output holds
        hold = pt_out;
        repeat (6) @(negedge clk);
        check(pt_out == hold, "R6 pt holds", pt_out, hold);

        // R7: back to back, second start in the done cycle
        issue(128'h3925841d02dc09fbdc118597196a0b32, 128'h2b7e151628aed2a6abf7158809cf4f3c,
              128'h3243f6a8885a308d313198a2e0370734, "R7 first of pair");
        do @(negedge clk); while (!done);
        issue(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h000102030405060708090a0b0c0d0e0f,
              128'h00112233445566778899aabbccddeeff, "R7 second of pair");
        drain();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule